// File: doc/BRIEF.md
# DPLL Lock Qualification and Retry Controller

This block runs the calibration of a frequency-tracking DPLL. When it gets a start request, it takes the measured host bus frequency in MHz and derives a target window from it. The low bound is the bus frequency scaled by 48/66. The high bound is two above the low bound. The block presents both bounds together with a tuning enable. It then watches the DPLL's raw lock bit, one sample per tick.

Each attempt has two phases:
- **Seek.** The block waits a bounded number of samples for lock to appear.
- **Hold.** Lock must then stay asserted without a break for a long run of further samples.

A confirmed lock turns tuning off, keeps the window bounds and raises the calibrated flag. If an attempt runs out of seek samples, or loses lock during the hold run, the window is rewritten with tuning off and a new attempt begins. When the last allowed attempt fails, the failed flag rises. Both flags stay set until the next start request or reset.

Top module: `dpll_cal_ctrl`

## Requirements
- R1: After reset, both window bounds are 0 and the tuning enable, calibrated flag and failed flag are all 0.
- R2: One cycle after start_i, win_low_o equals floor(bus_mhz_i × 48 / 66) and win_high_o equals win_low_o + 2. Both bounds keep those values until the next start_i.
- R3: start_i sets the tuning enable, clears both flags and begins attempt one. It does so from any state. It takes precedence over a success or failure that falls in the same cycle.
- R4: A cycle without tick_i changes nothing, whatever the value of lock_i.
- R5: In the seek phase, SEEK_LIMIT consecutive ticks that sample lock_i low fail the attempt. On a tick that samples lock_i high, the block moves to the hold phase instead.
- R6: In the hold phase, HOLD_LIMIT further ticks that all sample lock_i high confirm lock. One cycle after the last of those ticks, the calibrated flag is 1 and the tuning enable is 0.
- R7: A tick in the hold phase that samples lock_i low fails the attempt. This applies to every position in the hold run, including the last one.
- R8: A failed attempt clears the tuning enable, keeps both bounds and starts a new seek. Tuning stays off for the retries. The failure of attempt MAX_TRIES raises the failed flag.
- R9: The calibrated and failed flags are never both 1. Once set, each one holds until start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new calibration run |
| bus_mhz_i | input | FREQ_W | Measured host bus frequency in MHz |
| lock_i | input | 1 | Raw DPLL lock indication |
| tick_i | input | 1 | Sample strobe for lock_i |
| win_low_o | output | BOUND_W | Window low bound |
| win_high_o | output | BOUND_W | Window high bound |
| tune_en_o | output | 1 | DPLL tuning enable |
| cal_done_o | output | 1 | Calibration succeeded |
| cal_fail_o | output | 1 | All attempts failed |

## Verification
A start request can arrive in the same cycle as the tick that would finish calibration. That tick is either the final confirming hold sample or the last failing sample of the last attempt. The bench drives start_i together with such a terminal tick. It then expects both flags to be clear, tuning to be back on and the window to be recomputed from the new frequency. A done or fail flag that appears at that point shows that completion won over the restart.

// File: rtl/dpll_cal_pkg.sv
package dpll_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_HOLD,
        ST_DONE,
        ST_FAIL
    } cal_state_e;

endpackage

// File: rtl/dpll_cal_count.sv
// Saturation-free event counter that flags its final count value.
module dpll_cal_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/dpll_win_calc.sv
// Derives the DPLL frequency window from the bus clock in MHz.
module dpll_win_calc #(
    parameter int FREQ_W  = 8,
    parameter int BOUND_W = 16
) (
    input  logic [FREQ_W-1:0]  mhz_i,
    output logic [BOUND_W-1:0] low_o,
    output logic [BOUND_W-1:0] high_o
);
    localparam int PW = FREQ_W + 7;

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    always_comb begin
        prod   = PW'(mhz_i) * PW'(48);
        quot   = prod / PW'(66);
        low_o  = BOUND_W'(quot);
        high_o = BOUND_W'(quot) + BOUND_W'(2);
    end

endmodule

// File: rtl/dpll_cal_ctrl.sv
module dpll_cal_ctrl
    import dpll_cal_pkg::*;
#(
    parameter int FREQ_W     = 8,
    parameter int BOUND_W    = 16,
    parameter int SEEK_LIMIT = 20480,
    parameter int HOLD_LIMIT = 4096,
    parameter int MAX_TRIES  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FREQ_W-1:0]  bus_mhz_i,
    input  logic               lock_i,
    input  logic               tick_i,
    output logic [BOUND_W-1:0] win_low_o,
    output logic [BOUND_W-1:0] win_high_o,
    output logic               tune_en_o,
    output logic               cal_done_o,
    output logic               cal_fail_o
);

    typedef struct packed {
        cal_state_e         state;
        logic [BOUND_W-1:0] low;
        logic [BOUND_W-1:0] high;
        logic               tune;
        logic               done;
        logic               fail;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [BOUND_W-1:0] calc_low, calc_high;
    logic seek_clr, seek_inc, seek_last;
    logic hold_clr, hold_inc, hold_last;
    logic try_last;
    logic seek_miss, hold_drop, hold_ok, att_fail;

    dpll_win_calc #(.FREQ_W(FREQ_W), .BOUND_W(BOUND_W)) u_win (
        .mhz_i  (bus_mhz_i),
        .low_o  (calc_low),
        .high_o (calc_high)
    );

    // Event strobes of the current attempt
    always_comb begin
        seek_inc  = (r_q.state == ST_SEEK) && tick_i && !lock_i;
        hold_inc  = (r_q.state == ST_HOLD) && tick_i && lock_i;
        seek_miss = seek_inc && seek_last;
        hold_drop = (r_q.state == ST_HOLD) && tick_i && !lock_i;
        hold_ok   = hold_inc && hold_last;
        att_fail  = seek_miss || hold_drop;
        seek_clr  = start_i || (r_q.state != ST_SEEK) || seek_miss;
        hold_clr  = start_i || (r_q.state != ST_HOLD);
    end

    dpll_cal_count #(.LIMIT(SEEK_LIMIT)) u_seek (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (seek_clr),
        .inc_i  (seek_inc),
        .last_o (seek_last)
    );

    dpll_cal_count #(.LIMIT(HOLD_LIMIT)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hold_clr),
        .inc_i  (hold_inc),
        .last_o (hold_last)
    );

    dpll_cal_count #(.LIMIT(MAX_TRIES)) u_try (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .inc_i  (att_fail),
        .last_o (try_last)
    );

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.state = ST_SEEK;
            r_d.low   = calc_low;
            r_d.high  = calc_high;
            r_d.tune  = 1'b1;
            r_d.done  = 1'b0;
            r_d.fail  = 1'b0;
        end else begin
            case (r_q.state)
                ST_SEEK: begin
                    if (tick_i && lock_i)
                        r_d.state = ST_HOLD;
                end
                ST_HOLD: begin
                    if (hold_ok) begin
                        r_d.state = ST_DONE;
                        r_d.tune  = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
            if (att_fail) begin
                r_d.tune = 1'b0;
                if (try_last) begin
                    r_d.state = ST_FAIL;
                    r_d.fail  = 1'b1;
                end else begin
                    r_d.state = ST_SEEK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.low   <= '0;
            r_q.high  <= '0;
            r_q.tune  <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.fail  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign win_low_o  = r_q.low;
    assign win_high_o = r_q.high;
    assign tune_en_o  = r_q.tune;
    assign cal_done_o = r_q.done;
    assign cal_fail_o = r_q.fail;

endmodule

module dpll_cal_chk #(
    parameter int BOUND_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               tick_i,
    input logic [BOUND_W-1:0] win_low_o,
    input logic [BOUND_W-1:0] win_high_o,
    input logic               tune_en_o,
    input logic               cal_done_o,
    input logic               cal_fail_o
);

    AST_START_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tune_en_o && !cal_done_o && !cal_fail_o)); // R3

    AST_WINDOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (win_high_o == win_low_o + BOUND_W'(2))); // R2

    AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(win_low_o) && $stable(win_high_o))); // R2

    AST_NO_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !tick_i) |=> ($stable(tune_en_o) && $stable(cal_done_o) && $stable(cal_fail_o))); // R4

    AST_DONE_TUNE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> !tune_en_o); // R6

    AST_RETRY_TUNE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tune_en_o && !start_i) |=> !tune_en_o); // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done_o && cal_fail_o)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done_o && !start_i) |=> cal_done_o); // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_fail_o && !start_i) |=> cal_fail_o); // R9

endmodule

bind dpll_cal_ctrl dpll_cal_chk #(.BOUND_W(BOUND_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .win_low_o  (win_low_o),
    .win_high_o (win_high_o),
    .tune_en_o  (tune_en_o),
    .cal_done_o (cal_done_o),
    .cal_fail_o (cal_fail_o)
);

// File: tb/sim_dpll_cal_ctrl.sv
`timescale 1ns/1ps
module sim_dpll_cal_ctrl;
    localparam int FW    = 8;
    localparam int BW    = 16;
    localparam int SEEK  = 6;
    localparam int HOLD  = 4;
    localparam int TRIES = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FW-1:0] mhz = '0;
    logic lock = 1'b0;
    logic tick = 1'b0;
    logic [BW-1:0] wlo, whi;
    logic tune, done, fail;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dpll_cal_ctrl #(
        .FREQ_W(FW), .BOUND_W(BW),
        .SEEK_LIMIT(SEEK), .HOLD_LIMIT(HOLD), .MAX_TRIES(TRIES)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bus_mhz_i(mhz),
        .lock_i(lock), .tick_i(tick),
        .win_low_o(wlo), .win_high_o(whi), .tune_en_o(tune),
        .cal_done_o(done), .cal_fail_o(fail)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    endtask

    task automatic do_start(input int m);
        @(negedge clk);
        mhz = FW'(m); start = 1'b1; tick = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic tk(input logic l);
        @(negedge clk);
        lock = l; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic int exp_low(input int m);
        return (m * 48) / 66;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 low", int'(wlo), 0);
        chk("R1 high", int'(whi), 0);
        chk("R1 tune", int'(tune), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        rst_n = 1'b1;

        // R2 exhaustive window sweep
        for (int m = 0; m < 256; m++) begin
            do_start(m);
            chk($sformatf("R2 low mhz=%0d", m), int'(wlo), exp_low(m));
            chk($sformatf("R2 high mhz=%0d", m), int'(whi), exp_low(m) + 2);
        end
        chk("R3 tune after start", int'(tune), 1);

        // R5/R6 lock appearing at each seek position
        for (int j = 0; j < SEEK; j++) begin
            do_start(100);
            for (int i = 0; i < j; i++) tk(1'b0);
            tk(1'b1);
            for (int i = 0; i < HOLD - 1; i++) tk(1'b1);
            chk($sformatf("R6 not yet done j=%0d", j), int'(done), 0);
            chk($sformatf("R6 tune kept j=%0d", j), int'(tune), 1);
            tk(1'b1);
            chk($sformatf("R6 done j=%0d", j), int'(done), 1);
            chk($sformatf("R6 tune off j=%0d", j), int'(tune), 0);
            chk($sformatf("R6 low kept j=%0d", j), int'(wlo), exp_low(100));
        end

        // R5 seek timeout boundary
        do_start(66);
        for (int i = 0; i < SEEK - 1; i++) tk(1'b0);
        chk("R5 tune before timeout", int'(tune), 1);
        tk(1'b0);
        chk("R5 tune after timeout", int'(tune), 0);
        chk("R5 no flag after one miss", int'(done) + int'(fail), 0);

        // R7 drop at each hold position, then R8 retry succeeds
        for (int k = 0; k < HOLD; k++) begin
            do_start(120);
            tk(1'b1);
            for (int i = 0; i < k; i++) tk(1'b1);
            tk(1'b0);
            chk($sformatf("R7 tune off k=%0d", k), int'(tune), 0);
            chk($sformatf("R7 no done k=%0d", k), int'(done), 0);
            tk(1'b1);
            for (int i = 0; i < HOLD; i++) tk(1'b1);
            chk($sformatf("R8 retry done k=%0d", k), int'(done), 1);
            chk($sformatf("R8 retry tune k=%0d", k), int'(tune), 0);
            chk($sformatf("R8 high kept k=%0d", k), int'(whi), exp_low(120) + 2);
        end

        // R8 all attempts fail
        do_start(33);
        for (int i = 0; i < SEEK * TRIES - 1; i++) tk(1'b0);
        chk("R8 not failed early", int'(fail), 0);
        tk(1'b0);
        chk("R8 failed", int'(fail), 1);
        chk("R8 tune off", int'(tune), 0);
        chk("R8 low kept", int'(wlo), exp_low(33));
        // R9 sticky fail while lock toggles
        for (int i = 0; i < 6; i++) tk(1'b1);
        chk("R9 fail sticky", int'(fail), 1);
        chk("R9 exclusive", int'(done), 0);

        // R4 lock high without tick
        do_start(80);
        @(negedge clk); lock = 1'b1;
        repeat (30) @(negedge clk);
        chk("R4 no progress done", int'(done), 0);
        chk("R4 no progress tune", int'(tune), 1);
        tk(1'b1);
        for (int i = 0; i < HOLD; i++) tk(1'b1);
        chk("R4 progress on ticks", int'(done), 1);
        repeat (10) @(negedge clk);
        chk("R9 done sticky", int'(done), 1);

        // R3 start clears done
        do_start(90);
        chk("R3 start clears done", int'(done), 0);

        // R3 start coincides with the final hold tick
        tk(1'b1);
        for (int i = 0; i < HOLD - 1; i++) tk(1'b1);
        @(negedge clk);
        lock = 1'b1; tick = 1'b1; start = 1'b1; mhz = 8'd50;
        @(negedge clk);
        tick = 1'b0; start = 1'b0;
        chk("R3 collide done", int'(done), 0);
        chk("R3 collide tune", int'(tune), 1);
        chk("R3 collide low", int'(wlo), exp_low(50));

        // R3 start coincides with the final failing tick
        for (int i = 0; i < SEEK * TRIES - 1; i++) tk(1'b0);
        @(negedge clk);
        lock = 1'b0; tick = 1'b1; start = 1'b1; mhz = 8'd200;
        @(negedge clk);
        tick = 1'b0; start = 1'b0;
        chk("R3 collide fail", int'(fail), 0);
        chk("R3 collide tune2", int'(tune), 1);
        chk("R3 collide high", int'(whi), exp_low(200) + 2);

        summary();
    end
endmodule